// File: doc/BRIEF.md
# Windowed Event Watchdog

This block watches an active-low event line that some other part of the chip must pulse once per nominal interval. A slow periodic tick enable, produced elsewhere, paces an 8-bit interval counter. Each falling edge of the event line is compared against an early bound and a late bound on that counter. An event that lands inside the window restarts the interval. An event that lands before the window opens is an error. So is a missing event by the time the window closes. The default window is 16 to 20 ticks around a nominal 18 ticks of a 1 ms tick, and both bounds are parameters.

The event line is synchronised into the clock domain and reduced to a single falling-edge pulse, so a line held low for many cycles counts as one event. After reset the watchdog waits in an idle state. The first event only starts timing. Once raised, the error output stays high until the next synchronous reset.

Top module: `evt_window_wdog`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `err` is 0 and the watchdog is idle.
- R2: The first falling edge of `event_n` after reset starts timing from a count of 0 and never raises `err`, however long after reset it arrives.
- R3: A low level on `event_n` that lasts many cycles and many ticks counts as a single event, taken at its falling edge.
- R4: An event that arrives while the tick count since the last accepted event is below `EARLY` sets `err`.
- R5: An event that arrives with the count between `EARLY` and `LATE` inclusive leaves `err` at 0 and restarts the count at 0. Consecutive intervals of this kind never raise `err`.
- R6: Without an event, the tick that would take the count past `LATE` sets `err`. This is the (`LATE`+1)-th tick after the last accepted event.
- R7: Once set, `err` stays 1 through any further events and ticks, and only `rst` clears it.
- R8: The count advances only on clock cycles where `tick_en` is 1. Clock cycles without `tick_en` do not move it toward the late bound.
- R9: The bounds are inclusive. A count of exactly `EARLY` and a count of exactly `LATE` are accepted. A count of `EARLY`-1 is an early error.
- R10: While idle before the first event, no number of ticks raises `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timebase tick that advances the interval count |
| event_n | input | 1 | Active-low monitored event, asynchronous to `clk` |
| err | output | 1 | Sticky window violation flag |

## Verification
Three internal faults show up at the ports. A counter that fails to clear on an accepted event makes the next good interval look late. A count that moves on plain clock cycles makes a slow tick look late. An edge detector that passes a level through makes a held-low event look early. In each case `err` rises within one interval, at most `LATE`+1 ticks after the fault. An early or late decision reaches `err` a fixed few clocks after the event edge or the deciding tick: two synchroniser stages, then the edge register, then the state register. A state machine that could leave the error state would show as `err` falling without a reset.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_TIMING = 2'd1,
        WD_ERROR  = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctrl_t;

    function automatic logic in_window(input int unsigned c,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (c >= lo) && (c <= hi);
    endfunction

endpackage

// File: rtl/wdw_sync_edge.sv
module wdw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_n,
    output logic fall
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LEN-2:0], din_n};
        end
    end

    assign fall = chain_q[LEN-1] & ~chain_q[LEN-2];
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
    import wdw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctrl.clr) begin
            cnt_q <= '0;
        end else if (ctrl.inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EARLY = 16,
    parameter int LATE  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cnt,
    output wd_state_e        state,
    output cnt_ctrl_t        ctrl
);
    localparam logic [CNT_W-1:0] LATE_C = CNT_W'(LATE);

    wd_state_e state_q, state_d;
    logic      ok_win;

    assign ok_win = in_window(int'(cnt), EARLY, LATE);

    always_comb begin
        state_d  = state_q;
        ctrl.clr = 1'b0;
        ctrl.inc = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (fall) begin
                    state_d  = WD_TIMING;
                    ctrl.clr = 1'b1;
                end
            end
            WD_TIMING: begin
                if (fall) begin
                    if (ok_win) begin
                        ctrl.clr = 1'b1;
                    end else begin
                        state_d = WD_ERROR;
                    end
                end else if (tick_en) begin
                    if (cnt >= LATE_C) begin
                        state_d = WD_ERROR;
                    end else begin
                        ctrl.inc = 1'b1;
                    end
                end
            end
            default: state_d = WD_ERROR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/evt_window_wdog.sv
module evt_window_wdog
    import wdw_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int EARLY       = 16,
    parameter int LATE        = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic event_n,
    output logic err
);
    logic             evt_fall;
    logic [CNT_W-1:0] cnt_q;
    wd_state_e        state_q;
    cnt_ctrl_t        cnt_ctrl;

    wdw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din_n (event_n),
        .fall  (evt_fall)
    );

    wdw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctrl (cnt_ctrl),
        .cnt  (cnt_q)
    );

    wdw_fsm #(.CNT_W(CNT_W), .EARLY(EARLY), .LATE(LATE)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .fall    (evt_fall),
        .tick_en (tick_en),
        .cnt     (cnt_q),
        .state   (state_q),
        .ctrl    (cnt_ctrl)
    );

    assign err = (state_q == WD_ERROR);
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
    import wdw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EARLY = 16,
    parameter int LATE  = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             err,
    input wd_state_e        state,
    input logic [CNT_W-1:0] cnt,
    input logic             fall
);
    localparam logic [CNT_W-1:0] EARLY_C = CNT_W'(EARLY);
    localparam logic [CNT_W-1:0] LATE_C  = CNT_W'(LATE);

    initial begin
        a_cfg_bounds: assert (EARLY <= LATE && LATE < (2**CNT_W) - 1);
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == WD_IDLE && !err));

    a_r2_first_event_starts: assert property (@(posedge clk) disable iff (rst)
        (state == WD_IDLE && fall) |=> (state == WD_TIMING && cnt == '0 && !err));

    a_r4_early_error: assert property (@(posedge clk) disable iff (rst)
        (state == WD_TIMING && fall && cnt < EARLY_C) |=> err);

    a_r5_accept_restart: assert property (@(posedge clk) disable iff (rst)
        (state == WD_TIMING && fall && cnt >= EARLY_C && cnt <= LATE_C)
            |=> (cnt == '0 && !err));

    a_r6_late_error: assert property (@(posedge clk) disable iff (rst)
        (state == WD_TIMING && tick_en && !fall && cnt == LATE_C) |=> err);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (state == WD_TIMING && !tick_en && !fall) |=> $stable(cnt));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == WD_IDLE) |-> (cnt == '0 && !err));
endmodule

bind evt_window_wdog wdw_checker #(
    .CNT_W (CNT_W),
    .EARLY (EARLY),
    .LATE  (LATE)
) u_wdw_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .err     (err),
    .state   (state_q),
    .cnt     (cnt_q),
    .fall    (evt_fall)
);

// File: tb/test_evt_window_wdog.sv
`timescale 1ns/1ps
module test_evt_window_wdog;
    localparam int EARLY = 16;
    localparam int LATE  = 20;
    localparam int NV    = 9;
    localparam int GAP [NV] = '{18, 16, 20, 15, 21, 0, 1, 19, 17};
    localparam bit EXP [NV] = '{0,  0,  0,  1,  1,  1, 1, 0,  0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic event_n = 1'b1;
    logic err;

    int checks = 0;
    int errors = 0;

    evt_window_wdog #(.CNT_W(8), .EARLY(EARLY), .LATE(LATE), .SYNC_STAGES(2)) i_evt_window_wdog (
        .clk(clk), .rst(rst), .tick_en(tick_en), .event_n(event_n), .err(err)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: err=%b expected %b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick_en = 1'b0; event_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_event();
        event_n = 1'b0;
        repeat (3) @(negedge clk);
        event_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check(err, 1'b0, "R1", "during reset");
        do_reset();
        check(err, 1'b0, "R1", "after reset");

        // Table of single intervals
        for (int v = 0; v < NV; v++) begin
            string req;
            do_reset();
            pulse_event();
            check(err, 1'b0, "R2", "first event");
            ticks(GAP[v]);
            if (GAP[v] > LATE) begin
                check(err, 1'b1, "R6", "late without event");
            end else begin
                check(err, 1'b0, "R8", "within count before event");
                pulse_event();
                if (GAP[v] == EARLY || GAP[v] == LATE || GAP[v] == EARLY - 1)
                    req = "R9";
                else if (EXP[v])
                    req = "R4";
                else
                    req = "R5";
                check(err, EXP[v], req, $sformatf("event after %0d ticks", GAP[v]));
            end
        end

        // R10 and R2: idle ticks, late first event
        do_reset();
        ticks(300);
        check(err, 1'b0, "R10", "idle ticks");
        pulse_event();
        check(err, 1'b0, "R2", "late first event");
        // R5: consecutive good intervals
        for (int k = 0; k < 4; k++) begin
            ticks(EARLY + k);
            pulse_event();
        end
        check(err, 1'b0, "R5", "consecutive good intervals");

        // R8: many clocks without tick_en
        repeat (400) @(negedge clk);
        ticks(18);
        pulse_event();
        check(err, 1'b0, "R8", "clocks without tick");

        // R3: long low counts once
        do_reset();
        pulse_event();
        ticks(18);
        event_n = 1'b0;
        repeat (3) @(negedge clk);
        ticks(5);
        check(err, 1'b0, "R3", "held low with ticks");
        event_n = 1'b1;
        repeat (4) @(negedge clk);
        ticks(13);
        pulse_event();
        check(err, 1'b0, "R3", "interval measured from falling edge");

        // R7: sticky error, cleared only by reset
        do_reset();
        pulse_event();
        ticks(3);
        pulse_event();
        check(err, 1'b1, "R4", "early event");
        ticks(18);
        pulse_event();
        check(err, 1'b1, "R7", "good event after error");
        ticks(30);
        check(err, 1'b1, "R7", "ticks after error");
        do_reset();
        check(err, 1'b0, "R7", "reset clears error");

        // R6: exact late boundary
        do_reset();
        pulse_event();
        ticks(LATE);
        check(err, 1'b0, "R9", "count at late bound");
        ticks(1);
        check(err, 1'b1, "R6", "one tick past late bound");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule